// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block gathers up to eight interrupt request lines from I/O devices and turns them into a single interrupt line toward the CPU. Each request is captured on its rising edge into a pending register. A fixed-priority resolver picks one eligible source, with input 0 first and input 7 last. A source is eligible when it is pending and no source of equal or higher priority is in service. The CPU answers the interrupt with a one-cycle acknowledge pulse. The block then places the number of the chosen source on its data output, and the CPU uses that number to index its vector table.

Acknowledging a source moves it from pending to in service. It stays in service until the CPU sends an end-of-interrupt pulse. That pulse retires the highest-priority source currently in service, so nested handlers unwind in order. A cascade output reports that any request is pending, even one that is held back by an in-service source. A master controller can use this output to learn that this controller, acting as a slave, has work waiting.

The sequencer has three states:
- ST_IDLE moves to ST_PEND when an eligible source exists (transition "raise").
- ST_PEND holds the interrupt output high and moves to ST_ACK when the acknowledge input is high (transition "grant").
- ST_ACK drives the source number for one cycle and then always returns to ST_IDLE (transition "release").

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, int_out, data_out and casc_out are all 0.
- R2: A request is captured only on a 0-to-1 transition of its irq_in bit. A line that stays high after its request has been acknowledged does not raise a new request until it goes low and then high again.
- R3: int_out goes high in the cycle after the controller, in ST_IDLE, holds an eligible source (raise). It stays high until that request is acknowledged.
- R4: When ack_in is sampled high while int_out is high (grant), in the next cycle int_out is 0 and data_out carries the source number as an unsigned value in its low bits, with the upper bits 0.
- R5: Among eligible pending sources, the lowest index is granted.
- R6: A grant clears the pending bit of the chosen source and sets its in-service bit.
- R7: An in-service source blocks pending sources of equal or lower priority from raising int_out. A pending source of higher priority still raises it (nesting).
- R8: An eoi_in pulse clears the lowest-index in-service bit only. When eoi_in and a grant occur in the same cycle, the clear applies to the old in-service set before the new bit is set.
- R9: data_out is 0 in every cycle other than the one that follows a grant.
- R10: An ack_in pulse while int_out is low has no effect: data_out stays 0 and the pending and in-service state are unchanged.
- R11: casc_out is 1 whenever any request is pending, including a request that is blocked by an in-service source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Request lines, one per source; bit 0 has the highest priority |
| ack_in | input | 1 | One-cycle acknowledge from the CPU |
| eoi_in | input | 1 | One-cycle end-of-interrupt; retires the highest-priority in-service source |
| int_out | output | 1 | Interrupt request to the CPU |
| data_out | output | 8 | Number of the granted source during the cycle after a grant; 0 at all other times |
| casc_out | output | 1 | Any request pending, for a master controller |

## Verification
A corrupted pending bit shows on casc_out in the next cycle. It also shows on int_out one cycle after the sequencer reaches ST_IDLE. A wrong in-service bit stays hidden until a request of equal or lower priority arrives. At that point int_out rises when it should not, or stays low when it should rise, and the error becomes visible one or two cycles after the end-of-interrupt pulse that should have released the block. For that reason the stimulus puts nested and blocked requests around each end-of-interrupt pulse. A wrong priority choice or a wrong latched source number appears on data_out in the single cycle after the grant.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_ACK  = 2'd2
    } vic_state_e;
endpackage

// File: rtl/vic_req_latch.sv
module vic_req_latch #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic prev_q;
        logic pend_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= irq[i];
                pend_q <= (pend_q | (irq[i] & ~prev_q)) & ~clr[i];
            end
        end
        assign pend[i] = pend_q;
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N_SRC = 8,
    parameter int ID_W  = 3
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] insvc,
    output logic [N_SRC-1:0] elig,
    output logic [ID_W-1:0]  win_id,
    output logic             win_vld
);
    logic [N_SRC-1:0] blk;

    for (genvar i = 0; i < N_SRC; i++) begin : g_blk
        if (i == 0) begin : g_first
            assign blk[i] = insvc[i];
        end else begin : g_rest
            assign blk[i] = blk[i-1] | insvc[i];
        end
        assign elig[i] = pend[i] & ~blk[i];
    end

    always_comb begin
        win_id = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) win_id = ID_W'(i);
        end
    end

    assign win_vld = |elig;
endmodule

// File: rtl/vic_isr.sv
module vic_isr #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set,
    input  logic             eoi,
    output logic [N_SRC-1:0] insvc
);
    logic [N_SRC-1:0] isr_q;
    logic [N_SRC-1:0] lowest;

    assign lowest = isr_q & (~isr_q + N_SRC'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (eoi ? (isr_q & ~lowest) : isr_q) | set;
    end

    assign insvc = isr_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 8,
    localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              ack_in,
    input  logic              eoi_in,
    output logic              int_out,
    output logic [DATA_W-1:0] data_out,
    output logic              casc_out
);
    vic_state_e       state_q, state_d;
    logic [N_SRC-1:0] pend_w, isr_q, elig_w, grant_oh;
    logic [ID_W-1:0]  win_id, vec_q;
    logic             win_vld, grant;

    assign grant    = (state_q == ST_PEND) && ack_in;
    assign grant_oh = grant ? (N_SRC'(1) << win_id) : '0;

    vic_req_latch #(.N_SRC(N_SRC)) u_latch (
        .clk(clk), .rst_n(rst_n), .irq(irq_in), .clr(grant_oh), .pend(pend_w)
    );

    vic_prio #(.N_SRC(N_SRC), .ID_W(ID_W)) u_prio (
        .pend(pend_w), .insvc(isr_q), .elig(elig_w), .win_id(win_id), .win_vld(win_vld)
    );

    vic_isr #(.N_SRC(N_SRC)) u_isr (
        .clk(clk), .rst_n(rst_n), .set(grant_oh), .eoi(eoi_in), .insvc(isr_q)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_vld) state_d = ST_PEND;
            ST_PEND: if (ack_in)  state_d = ST_ACK;
            ST_ACK:               state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (grant) vec_q <= win_id;
        end
    end

    always_comb begin
        int_out  = 1'b0;
        data_out = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PEND: int_out  = 1'b1;
            ST_ACK:  data_out = DATA_W'(vec_q);
            default: ;
        endcase
    end

    assign casc_out = |pend_w;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_in,
    input logic              int_out,
    input logic [DATA_W-1:0] data_out,
    input logic [N_SRC-1:0]  elig,
    input logic [N_SRC-1:0]  isr
);
    // R9
    data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_out != '0) |-> $past(int_out && ack_in));
    // R4
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out && ack_in) |=> !int_out);
    // R10
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_out && ack_in) |=> (data_out == '0));
    // R3
    int_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_out) |-> $past(elig != '0));
    // R6
    isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out && ack_in) |=> (isr != '0));
endmodule

bind irq_vector_ctrl vic_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_in(ack_in), .int_out(int_out),
    .data_out(data_out), .elig(elig_w), .isr(isr_q)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       ack = 1'b0, eoi = 1'b0;
    logic       int_o, casc_o;
    logic [7:0] data_o;
    int n_chk = 0, n_err = 0;
    bit done = 0, armed = 0;

    logic [7:0] m_irr, m_isr, m_prev;
    int m_st, m_cur;

    always #5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .ack_in(ack), .eoi_in(eoi),
        .int_out(int_o), .data_out(data_o), .casc_out(casc_o)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: st 0 idle, 1 interrupt raised, 2 vector cycle
    always @(posedge clk or negedge rst_n) begin : model
        int w;
        logic [7:0] nirr, nisr;
        if (!rst_n) begin
            m_irr = '0; m_isr = '0; m_prev = '0; m_st = 0; m_cur = 0;
        end else begin
            w = -1;
            for (int i = 0; i < 8; i++) begin
                if (m_isr[i]) break;
                if (m_irr[i]) begin w = i; break; end
            end
            nirr = m_irr | (irq & ~m_prev);
            m_prev = irq;
            nisr = m_isr;
            if (eoi) begin
                for (int i = 0; i < 8; i++) if (nisr[i]) begin nisr[i] = 1'b0; break; end
            end
            case (m_st)
                0: if (w >= 0) m_st = 1;
                1: if (ack && w >= 0) begin
                       m_cur = w; nirr[w] = 1'b0; nisr[w] = 1'b1; m_st = 2;
                   end
                default: m_st = 0;
            endcase
            m_irr = nirr;
            m_isr = nisr;
        end
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            chk(int_o == (m_st == 1), "R3 R7 model int_out", int'(int_o), int'(m_st == 1));
            chk(data_o == ((m_st == 2) ? 8'(m_cur) : 8'd0), "R4 R9 model data_out",
                int'(data_o), (m_st == 2) ? m_cur : 0);
            chk(casc_o == (m_irr != 0), "R11 model casc_out", int'(casc_o), int'(m_irr != 0));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_int();
        for (int k = 0; k < 20 && !int_o; k++) @(negedge clk);
        chk(int_o, "R3 int_out raised before ack", int'(int_o), 1);
    endtask

    task automatic do_ack(int exp, string tag);
        wait_int();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        chk(data_o == 8'(exp), tag, int'(data_o), exp);
        chk(!int_o, "R4 int_out low in vector cycle", int'(int_o), 0);
        cyc(1);
        chk(data_o == 0, "R9 data_out cleared after vector cycle", int'(data_o), 0);
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        cyc(1);
        eoi = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        armed = 1;
        chk(!int_o && data_o == 0 && !casc_o, "R1 reset outputs", int'({int_o, casc_o}) + int'(data_o), 0);

        irq = 8'h08;
        cyc(1);
        chk(casc_o, "R11 casc after request edge", int'(casc_o), 1);
        chk(!int_o, "R3 int_out not yet high", int'(int_o), 0);
        cyc(1);
        chk(int_o, "R3 int_out raised", int'(int_o), 1);
        do_ack(3, "R4 vector of source 3");

        cyc(4);
        chk(!int_o && !casc_o, "R2 R6 held level not re-latched", int'({int_o, casc_o}), 0);
        irq = 8'h00; cyc(1);
        irq = 8'h08; cyc(2);
        chk(casc_o, "R2 new edge latched", int'(casc_o), 1);
        chk(!int_o, "R7 equal priority blocked", int'(int_o), 0);

        irq = 8'h28; cyc(3);
        chk(!int_o, "R7 lower priority blocked", int'(int_o), 0);
        irq = 8'h2a; cyc(2);
        chk(int_o, "R7 higher priority nests", int'(int_o), 1);
        do_ack(1, "R4 vector of source 1");
        do_eoi();
        cyc(3);
        chk(!int_o, "R8 eoi retired only source 1", int'(int_o), 0);
        do_eoi();
        cyc(2);
        chk(int_o, "R8 second eoi releases", int'(int_o), 1);
        do_ack(3, "R5 source 3 before 5");
        do_eoi();
        do_ack(5, "R4 vector of source 5");
        do_eoi();
        cyc(3);
        chk(!int_o && !casc_o, "R6 nothing left pending", int'({int_o, casc_o}), 0);

        irq = 8'h00; cyc(3);
        ack = 1'b1; cyc(1); ack = 1'b0;
        chk(data_o == 0 && !int_o, "R10 stray ack ignored", int'(data_o), 0);
        cyc(2);
        chk(!int_o && !casc_o, "R10 state unchanged", int'({int_o, casc_o}), 0);

        irq = 8'h54;
        do_ack(2, "R5 lowest of 2,4,6");
        do_eoi();
        do_ack(4, "R5 lowest of 4,6");
        do_eoi();
        do_ack(6, "R5 last of 6");
        do_eoi();

        irq = 8'h00; cyc(1);
        irq = 8'h81;
        do_ack(0, "R4 vector of source 0");
        do_eoi();
        do_ack(7, "R4 vector of source 7");
        do_eoi();

        irq = 8'h85;
        do_ack(2, "R4 vector of source 2");
        irq = 8'h87;
        wait_int();
        ack = 1'b1; eoi = 1'b1; cyc(1); ack = 1'b0; eoi = 1'b0;
        chk(data_o == 1, "R8 ack with eoi same cycle", int'(data_o), 1);
        do_eoi();
        cyc(3);
        chk(!int_o, "R8 in-service set emptied", int'(int_o), 0);

        cyc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule